// File: doc/BRIEF.md
# Color Palette Host Access Controller

This block is the host-side front end of a 256-entry lookup table in which every entry carries three 10-bit color components (red, green, blue). A host drives an access strobe, a read/write line, a two-bit select and a 10-bit data bus. Each access lands on one of four targets: an 8-bit address register, an 8-bit mode register, a bank of control registers reached indirectly through the address register, or the palette storage itself.

Palette entries are reached one component at a time. A component pointer steps red, green, blue; writes collect red and green in holding registers and commit the whole 30-bit word on the blue step, reads return the addressed entry's components in the same order. Only the blue step moves the address register forward, and writing the address register puts the pointer back on red. Bit 0 of the mode register selects between full 10-bit component transfers and an 8-bit bus mode. Every access takes one clock, and read data is registered.

Top module: `palette_host_port`

## Requirements
- R1: After reset the address register, mode register and component pointer are zero, the writable control registers read zero, and `rdata` is zero.
- R2: The select lines decode as 00 = address register, 01 = palette, 10 = control bank, 11 = mode register. Register writes take `wdata[7:0]`, and register reads return the value on `rdata[7:0]` with bits 9..8 zero.
- R3: Control locations 0 to 5 are read/write registers. A control-bank access reaches the location held in the address register, and a write changes no other location.
- R4: Control location 6 reads the constant `ID_CODE`, location 7 reads the parameter `REV_CODE`, and every other location from 8 to FFh reads zero. Writes to locations 6 and above have no effect.
- R5: Three palette writes load red, then green, then blue. On the blue write the word {red, green, blue} is stored at the addressed entry and the address register increments. The first two writes leave the address unchanged.
- R6: Three palette reads return red, then green, then blue of the addressed entry. The address register increments after the blue read only.
- R7: Writing the address register returns the component pointer to red. Accesses to the mode register, the address register (as reads) or the control bank do not move the pointer.
- R8: A blue step at address FFh wraps the address register to 00h.
- R9: When mode bit 0 is 0 (8-bit mode), a written component is stored as {wdata[7:0], 2'b00}, and a read returns component bits 9..2 on rdata[7:0] with bits 9..8 zero. When mode bit 0 is 1, all 10 bits pass in both directions.
- R10: `rdata` updates on the clock edge that ends a read access and holds its value through write and idle cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_en | input | 1 | Access strobe, one access per cycle it is high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| sel | input | 2 | Target select (see R2) |
| wdata | input | 10 | Host write data |
| rdata | output | 10 | Registered host read data |

## Verification
The bench sets `REV_CODE` to 8'h3C instead of its default, so a read of the revision slot shows that the value comes from the parameter. `ID_CODE` and the five-plus-one writable control registers stay at their defaults, which puts the boundary between location 5 (writable) and locations 6 and 7 (read-only) within reach of single accesses. With the default 8-bit address, the wrap from FFh to 00h can be reached in one directed step.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int COMP_W = 10;
  localparam int AW     = 8;
  localparam int WORD_W = 3 * COMP_W;
  localparam int REG_W  = 8;

  typedef enum logic [1:0] {
    SEL_ADDR = 2'd0,
    SEL_PAL  = 2'd1,
    SEL_CTRL = 2'd2,
    SEL_MODE = 2'd3
  } sel_e;

  typedef enum logic [1:0] {
    CMP_R = 2'd0,
    CMP_G = 2'd1,
    CMP_B = 2'd2
  } cmp_e;

  // host data -> stored component
  function automatic logic [COMP_W-1:0] comp_in(logic [COMP_W-1:0] d, logic wide);
    return wide ? d : {d[REG_W-1:0], 2'b00};
  endfunction

  // stored component -> host data
  function automatic logic [COMP_W-1:0] comp_out(logic [COMP_W-1:0] c, logic wide);
    return wide ? c : {2'b00, c[COMP_W-1:2]};
  endfunction

  function automatic logic [COMP_W-1:0] reg_out(logic [REG_W-1:0] r);
    return {{(COMP_W-REG_W){1'b0}}, r};
  endfunction
endpackage

// File: rtl/pal_comp_seq.sv
module pal_comp_seq
  import pal_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  input  logic clear,
  output cmp_e ptr,
  output logic last
);
  cmp_e ptr_q;

  assign ptr  = ptr_q;
  assign last = step && (ptr_q == CMP_B);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) ptr_q <= CMP_R;
    else if (step) begin
      case (ptr_q)
        CMP_R:   ptr_q <= CMP_G;
        CMP_G:   ptr_q <= CMP_B;
        default: ptr_q <= CMP_R;
      endcase
    end
  end

  // R5
  ptr_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_q != cmp_e'(2'd3));

  // R7
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> ptr_q == CMP_R);
endmodule

// File: rtl/pal_ctrl_bank.sv
module pal_ctrl_bank
  import pal_pkg::*;
#(
  parameter int             WR_N     = 6,
  parameter logic [REG_W-1:0] ID_CODE  = 8'hA5,
  parameter logic [REG_W-1:0] REV_CODE = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    idx,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] rdata
);
  localparam int ID_LOC  = WR_N;
  localparam int REV_LOC = WR_N + 1;

  logic [WR_N-1:0][REG_W-1:0] regs_q;
  logic ro_hit;

  assign ro_hit = (int'(idx) >= WR_N);

  for (genvar g = 0; g < WR_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs_q[g] <= '0;
      else if (wr_en && int'(idx) == g) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (int'(idx) == ID_LOC) rdata = ID_CODE;
    else if (int'(idx) == REV_LOC) rdata = REV_CODE;
    else begin
      for (int i = 0; i < WR_N; i++)
        if (int'(idx) == i) rdata = regs_q[i];
    end
  end

  // R4
  ro_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && ro_hit |=> $stable(regs_q));
endmodule

// File: rtl/pal_lut_ram.sv
module pal_lut_ram
  import pal_pkg::*;
#(
  parameter int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wword,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rword
);
  logic [WORD_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wword;
  end

  assign rword = mem[raddr];
endmodule

// File: rtl/palette_host_port.sv
module palette_host_port
  import pal_pkg::*;
#(
  parameter int               WR_N     = 6,
  parameter logic [REG_W-1:0] ID_CODE  = 8'hA5,
  parameter logic [REG_W-1:0] REV_CODE = 8'h02
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_en,
  input  logic              rd_wr,
  input  logic [1:0]        sel,
  input  logic [COMP_W-1:0] wdata,
  output logic [COMP_W-1:0] rdata
);
  sel_e              sel_t;
  logic              acc_rd, acc_wr, pal_step, addr_wr, blue_done, wide;
  cmp_e              ptr;
  logic [AW-1:0]     addr_q;
  logic [REG_W-1:0]  mode_q, ctrl_rd;
  logic [COMP_W-1:0] red_h, grn_h, comp_w, comp_sel;
  logic              ram_we;
  logic [WORD_W-1:0] ram_wword, ram_rword;
  logic [COMP_W-1:0] rd_mux;

  assign sel_t    = sel_e'(sel);
  assign acc_rd   = acc_en && rd_wr;
  assign acc_wr   = acc_en && !rd_wr;
  assign pal_step = acc_en && (sel_t == SEL_PAL);
  assign addr_wr  = acc_wr && (sel_t == SEL_ADDR);
  assign wide     = mode_q[0];
  assign comp_w   = comp_in(wdata, wide);

  pal_comp_seq i_seq (
    .clk(clk), .rst_n(rst_n), .step(pal_step), .clear(addr_wr),
    .ptr(ptr), .last(blue_done)
  );

  pal_ctrl_bank #(.WR_N(WR_N), .ID_CODE(ID_CODE), .REV_CODE(REV_CODE)) i_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(acc_wr && (sel_t == SEL_CTRL)),
    .idx(addr_q), .wdata(wdata[REG_W-1:0]), .rdata(ctrl_rd)
  );

  assign ram_we    = acc_wr && blue_done;
  assign ram_wword = {red_h, grn_h, comp_w};

  pal_lut_ram i_ram (
    .clk(clk), .we(ram_we), .waddr(addr_q), .wword(ram_wword),
    .raddr(addr_q), .rword(ram_rword)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q <= '0;
      mode_q <= '0;
      red_h  <= '0;
      grn_h  <= '0;
    end else begin
      if (addr_wr) addr_q <= wdata[AW-1:0];
      else if (blue_done) addr_q <= addr_q + 1'b1;
      if (acc_wr && sel_t == SEL_MODE) mode_q <= wdata[REG_W-1:0];
      if (acc_wr && pal_step && ptr == CMP_R) red_h <= comp_w;
      if (acc_wr && pal_step && ptr == CMP_G) grn_h <= comp_w;
    end
  end

  always_comb begin
    case (ptr)
      CMP_R:   comp_sel = ram_rword[WORD_W-1 -: COMP_W];
      CMP_G:   comp_sel = ram_rword[2*COMP_W-1 -: COMP_W];
      default: comp_sel = ram_rword[COMP_W-1:0];
    endcase
    case (sel_t)
      SEL_ADDR: rd_mux = reg_out(addr_q);
      SEL_MODE: rd_mux = reg_out(mode_q);
      SEL_CTRL: rd_mux = reg_out(ctrl_rd);
      default:  rd_mux = comp_out(comp_sel, wide);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rdata <= '0;
    else if (acc_rd) rdata <= rd_mux;
  end

  // R5
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    blue_done |=> addr_q == $past(addr_q) + 8'd1);

  // R6
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pal_step && !blue_done |=> $stable(addr_q));

  // R9
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we && !wide |-> ram_wword[1:0] == 2'b00);

  // R10
  rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_rd |=> $stable(rdata));
endmodule

// File: tb/test_palette_host_port.sv
module test_palette_host_port;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] EXP_ID  = 8'hA5;
  localparam logic [7:0] EXP_REV = 8'h3C;
  localparam int NV = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic acc_en = 1'b0;
  logic rd_wr = 1'b0;
  logic [1:0] sel = 2'd0;
  logic [9:0] wdata = '0;
  logic [9:0] rdata;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  palette_host_port #(.REV_CODE(EXP_REV)) i_palette_host_port (
    .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .rd_wr(rd_wr),
    .sel(sel), .wdata(wdata), .rdata(rdata)
  );

  // {rd, sel, wdata, expected}; sel: 0 addr, 1 palette, 2 control, 3 mode
  localparam logic [22:0] VEC [NV] = '{
    {1'b1,2'd0,10'h000,10'h000}, // 0  R1 address
    {1'b1,2'd3,10'h000,10'h000}, // 1  R1 mode
    {1'b1,2'd2,10'h000,10'h000}, // 2  R1 control 0
    {1'b0,2'd3,10'h001,10'h000}, // 3  R2 mode = 10-bit
    {1'b1,2'd3,10'h000,10'h001}, // 4  R2
    {1'b0,2'd0,10'h010,10'h000}, // 5  R2
    {1'b1,2'd0,10'h000,10'h010}, // 6  R2
    {1'b0,2'd1,10'h3FF,10'h000}, // 7  R5 red
    {1'b0,2'd1,10'h155,10'h000}, // 8  R5 green
    {1'b1,2'd0,10'h000,10'h010}, // 9  R5 address unchanged
    {1'b0,2'd1,10'h2AA,10'h000}, // 10 R5 blue
    {1'b1,2'd0,10'h000,10'h011}, // 11 R5 increment
    {1'b0,2'd0,10'h010,10'h000}, // 12 R7
    {1'b1,2'd1,10'h000,10'h3FF}, // 13 R6
    {1'b1,2'd1,10'h000,10'h155}, // 14 R6
    {1'b1,2'd1,10'h000,10'h2AA}, // 15 R6
    {1'b1,2'd0,10'h000,10'h011}, // 16 R6
    {1'b0,2'd0,10'h003,10'h000}, // 17 R3
    {1'b0,2'd2,10'h0C3,10'h000}, // 18 R3
    {1'b1,2'd2,10'h000,10'h0C3}, // 19 R3
    {1'b0,2'd0,10'h005,10'h000}, // 20 R3
    {1'b0,2'd2,10'h35A,10'h000}, // 21 R3 upper bits dropped
    {1'b1,2'd2,10'h000,10'h05A}, // 22 R3
    {1'b0,2'd0,10'h003,10'h000}, // 23 R3
    {1'b1,2'd2,10'h000,10'h0C3}, // 24 R3 neighbour untouched
    {1'b0,2'd0,10'h006,10'h000}, // 25 R4
    {1'b0,2'd2,10'h000,10'h000}, // 26 R4
    {1'b1,2'd2,10'h000,{2'b00,EXP_ID}},  // 27 R4
    {1'b0,2'd0,10'h007,10'h000}, // 28 R4
    {1'b0,2'd2,10'h0FF,10'h000}, // 29 R4
    {1'b1,2'd2,10'h000,{2'b00,EXP_REV}}, // 30 R4
    {1'b0,2'd0,10'h009,10'h000}, // 31 R4
    {1'b0,2'd2,10'h0FF,10'h000}, // 32 R4
    {1'b1,2'd2,10'h000,10'h000}, // 33 R4
    {1'b0,2'd0,10'h020,10'h000}, // 34 R4
    {1'b0,2'd2,10'h077,10'h000}, // 35 R4
    {1'b1,2'd2,10'h000,10'h000}, // 36 R4
    {1'b0,2'd3,10'h000,10'h000}, // 37 R9 8-bit mode
    {1'b0,2'd0,10'h040,10'h000}, // 38 R9
    {1'b0,2'd1,10'h3AB,10'h000}, // 39 R9
    {1'b0,2'd1,10'h0CD,10'h000}, // 40 R9
    {1'b0,2'd1,10'h012,10'h000}, // 41 R9
    {1'b0,2'd3,10'h001,10'h000}, // 42 R9 10-bit mode
    {1'b0,2'd0,10'h040,10'h000}, // 43 R9
    {1'b1,2'd1,10'h000,10'h2AC}, // 44 R9
    {1'b1,2'd1,10'h000,10'h334}, // 45 R9
    {1'b1,2'd1,10'h000,10'h048}, // 46 R9
    {1'b0,2'd3,10'h000,10'h000}, // 47 R9
    {1'b0,2'd0,10'h040,10'h000}, // 48 R9
    {1'b1,2'd1,10'h000,10'h0AB}, // 49 R9
    {1'b1,2'd1,10'h000,10'h0CD}, // 50 R9
    {1'b1,2'd1,10'h000,10'h012}, // 51 R9
    {1'b0,2'd0,10'h040,10'h000}, // 52 R7
    {1'b1,2'd1,10'h000,10'h0AB}, // 53 R7
    {1'b0,2'd0,10'h040,10'h000}, // 54 R7
    {1'b1,2'd1,10'h000,10'h0AB}, // 55 R7 back on red
    {1'b1,2'd3,10'h000,10'h000}, // 56 R7 mode read mid-sequence
    {1'b1,2'd1,10'h000,10'h0CD}, // 57 R7 pointer kept
    {1'b1,2'd1,10'h000,10'h012}, // 58 R6
    {1'b1,2'd0,10'h000,10'h041}  // 59 R6
  };

  task automatic acc(input logic r, input logic [1:0] s, input logic [9:0] d);
    @(negedge clk);
    acc_en = 1'b1; rd_wr = r; sel = s; wdata = d;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic check(input string req, input logic [9:0] exp_v);
    n_chk++;
    if (rdata !== exp_v) begin
      n_bad++;
      $display("FAIL %s: rdata=%h expected=%h", req, rdata, exp_v);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=finish");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 10'h000);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i][22], VEC[i][21:20], VEC[i][19:10]);
      if (VEC[i][22]) check($sformatf("vector %0d", i), VEC[i][9:0]);
    end

    // R10: read value holds through writes and idle cycles
    acc(1'b1, 2'd0, 10'h000);
    check("R10", 10'h041);
    acc(1'b0, 2'd0, 10'h050);
    repeat (3) @(negedge clk);
    check("R10", 10'h041);

    // R8: wrap at FFh
    acc(1'b0, 2'd3, 10'h001);
    acc(1'b0, 2'd0, 10'h0FF);
    acc(1'b0, 2'd1, 10'h001);
    acc(1'b0, 2'd1, 10'h002);
    acc(1'b0, 2'd1, 10'h003);
    acc(1'b1, 2'd0, 10'h000);
    check("R8", 10'h000);
    acc(1'b0, 2'd0, 10'h0FF);
    acc(1'b1, 2'd1, 10'h000); check("R8", 10'h001);
    acc(1'b1, 2'd1, 10'h000); check("R8", 10'h002);
    acc(1'b1, 2'd1, 10'h000); check("R8", 10'h003);
    acc(1'b1, 2'd0, 10'h000); check("R8", 10'h000);

    // R1: reset in mid-run
    acc(1'b0, 2'd0, 10'h002);
    acc(1'b0, 2'd2, 10'h099);
    acc(1'b0, 2'd1, 10'h111);
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R1", 10'h000);
    rst_n = 1'b1;
    acc(1'b1, 2'd0, 10'h000); check("R1", 10'h000);
    acc(1'b1, 2'd3, 10'h000); check("R1", 10'h000);
    acc(1'b0, 2'd0, 10'h002);
    acc(1'b1, 2'd2, 10'h000); check("R1", 10'h000);

    summary();
  end
endmodule